// File: doc/BRIEF.md
# Two-Stage Watchdog with Configuration Lock

This block is an up-counting watchdog with two compare points. When the count reaches the first (bark) threshold, an interrupt level and a wakeup request go high, giving software a chance to react. When the count reaches the second (bite) threshold, a reset-request level goes high, and the system reset logic acts on it. Software keeps the watchdog quiet by rewriting ("petting") the count register before either point is reached.

A small register port gives access to control, both thresholds, the count and a one-way lock. Once software clears the lock, the control and threshold registers cannot be changed until reset. The count stays writable so that petting still works. Two inputs act on counting. A sleep indication can pause the counter, if software enables that option. An escalation input forces the watchdog off: it freezes the count and holds the current output levels.

Counting is governed by a four-state mode machine. IDLE means not enabled. RUN means counting. HOLD means paused for sleep. FROZEN means escalation is active. The transitions are:
- any state goes to FROZEN when escalation is active;
- FROZEN leaves when escalation drops, to IDLE, HOLD or RUN according to the control bits;
- RUN or HOLD goes to IDLE when the enable bit is cleared;
- IDLE goes to RUN or HOLD when the enable bit is set;
- RUN goes to HOLD when sleep is asserted with the pause option set;
- HOLD goes back to RUN when sleep drops or the pause option is cleared.

The state register updates one cycle after its inputs change. The counter follows the registered state.

Top module: `barkbite_watchdog`

## Requirements
- R1: Register map, by `reg_addr`:
  - 0: control. Bit 0 is enable; bit 1 is pause-in-sleep.
  - 1: lock. Bit 0.
  - 2: bark threshold.
  - 3: bite threshold.
  - 4: count.
  - Other addresses read 0 and ignore writes.
  - After reset: control reads 0, lock reads 1, both thresholds read all-ones, count reads 0, and all three outputs are 0.
- R2: Counting starts after enable is written to 1. The count first increments on the second clock edge after the write edge, then by one per cycle. With enable 0, the count does not change.
- R3: The counter saturates at all-ones and never wraps to zero.
- R4: With pause-in-sleep 1, the count holds while `sleep_i` is high. It resumes on the second edge after `sleep_i` falls. With pause-in-sleep 0, sleep has no effect.
- R5: `bark_irq` and `wake_req` go high on the edge after the count first satisfies count >= bark threshold. They stay high while that holds, and drop on the edge after the count is rewritten below the threshold.
- R6: `bite_rst` follows the same rule as R5, using the bite threshold.
- R7: Writing the lock register with bit 0 = 0 clears the lock. Writing 1 has no effect. Once clear, the lock stays clear until reset.
- R8: While the lock is clear, writes to control, bark threshold and bite threshold are ignored.
- R9: The count register is writable regardless of the lock. The written value appears on the write edge and takes priority over an increment on that edge.
- R10: While `esc_i` is high, the count does not advance, even with enable set, and the three outputs hold their values. After `esc_i` falls, outputs resume tracking on the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for `reg_addr` (combinational) |
| sleep_i | input | 1 | System sleep indication |
| esc_i | input | 1 | Escalation: forces the watchdog off |
| bark_irq | output | 1 | Bark interrupt level |
| wake_req | output | 1 | Wakeup request level (raised with bark) |
| bite_rst | output | 1 | Reset request level |

## Verification
The bench builds the block with `CNT_W = 8`, so the full count range is 256 values. It sweeps every bark threshold from 2 to 255, and then every bite threshold over the same range. Each case checks the exact edge on which the output rises, against a cycle count worked out by arithmetic in the bench. The narrow width also lets the bench drive the counter into saturation at all-ones within a few hundred cycles. Directed sequences then cover sleep pausing, escalation freezing and release timing, and the lock, which can only be cleared and can never be set again.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL  = 3'd0,
        A_LOCK  = 3'd1,
        A_BARK  = 3'd2,
        A_BITE  = 3'd3,
        A_COUNT = 3'd4
    } wdg_addr_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_HOLD,
        ST_FROZEN
    } wdg_state_e;

    typedef struct packed {
        logic pause_sleep;
        logic run;
    } wdg_ctrl_t;

    localparam int NUM_CMP = 2;   // 0: bark, 1: bite

endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
    import wdg_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [CNT_W-1:0]     reg_wdata,
    input  logic [CNT_W-1:0]     count_i,
    output logic [CNT_W-1:0]     reg_rdata,
    output wdg_ctrl_t            ctrl_o,
    output logic [CNT_W-1:0]     bark_th_o,
    output logic [CNT_W-1:0]     bite_th_o,
    output logic                 cnt_we_o,
    output logic [CNT_W-1:0]     cnt_wdata_o
);

    localparam int PAD_CTRL = CNT_W - 2;
    localparam int PAD_LOCK = CNT_W - 1;

    wdg_ctrl_t        ctrl_q;
    logic             open_q;
    logic [CNT_W-1:0] bark_q;
    logic [CNT_W-1:0] bite_q;

    logic wr_ctrl, wr_lock, wr_bark, wr_bite, wr_count;

    always_comb begin
        wr_ctrl  = reg_we && (reg_addr == A_CTRL);
        wr_lock  = reg_we && (reg_addr == A_LOCK);
        wr_bark  = reg_we && (reg_addr == A_BARK);
        wr_bite  = reg_we && (reg_addr == A_BITE);
        wr_count = reg_we && (reg_addr == A_COUNT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            open_q <= 1'b1;
            bark_q <= '1;
            bite_q <= '1;
        end else begin
            if (wr_lock && !reg_wdata[0]) begin
                open_q <= 1'b0;
            end
            if (open_q) begin
                if (wr_ctrl) ctrl_q <= wdg_ctrl_t'(reg_wdata[1:0]);
                if (wr_bark) bark_q <= reg_wdata;
                if (wr_bite) bite_q <= reg_wdata;
            end
        end
    end

    always_comb begin
        case (reg_addr)
            A_CTRL:  reg_rdata = {{PAD_CTRL{1'b0}}, ctrl_q};
            A_LOCK:  reg_rdata = {{PAD_LOCK{1'b0}}, open_q};
            A_BARK:  reg_rdata = bark_q;
            A_BITE:  reg_rdata = bite_q;
            A_COUNT: reg_rdata = count_i;
            default: reg_rdata = '0;
        endcase
    end

    assign ctrl_o      = ctrl_q;
    assign bark_th_o   = bark_q;
    assign bite_th_o   = bite_q;
    assign cnt_we_o    = wr_count;
    assign cnt_wdata_o = reg_wdata;

    // R7: once cleared the lock never returns to 1 before reset
    a_r7_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !open_q |=> !open_q);

    // R8: locked configuration does not move
    a_r8_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !open_q |=> ($stable(ctrl_q) && $stable(bark_q) && $stable(bite_q)));

endmodule

// File: rtl/wdg_core.sv
module wdg_core
    import wdg_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wdg_ctrl_t        ctrl_i,
    input  logic             sleep_i,
    input  logic             esc_i,
    input  logic             cnt_we_i,
    input  logic [CNT_W-1:0] cnt_wdata_i,
    output logic [CNT_W-1:0] count_o,
    output wdg_state_e       state_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    wdg_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q;
    logic             nap;

    assign nap = ctrl_i.pause_sleep && sleep_i;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (esc_i)            state_d = ST_FROZEN;
                else if (ctrl_i.run)  state_d = nap ? ST_HOLD : ST_RUN;
            end
            ST_RUN: begin
                if (esc_i)            state_d = ST_FROZEN;
                else if (!ctrl_i.run) state_d = ST_IDLE;
                else if (nap)         state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (esc_i)            state_d = ST_FROZEN;
                else if (!ctrl_i.run) state_d = ST_IDLE;
                else if (!nap)        state_d = ST_RUN;
            end
            ST_FROZEN: begin
                if (!esc_i) begin
                    if (!ctrl_i.run)  state_d = ST_IDLE;
                    else if (nap)     state_d = ST_HOLD;
                    else              state_d = ST_RUN;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Counter: software write wins, otherwise saturating increment in RUN
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (cnt_we_i) begin
            count_q <= cnt_wdata_i;
        end else if (state_q == ST_RUN && count_q != CNT_MAX) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count_o = count_q;
    assign state_o = state_q;

    // R3: no wrap from all-ones
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == CNT_MAX && !cnt_we_i) |=> count_q == CNT_MAX);

    // R9: a pet lands on the write edge
    a_r9_pet_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we_i |=> count_q == $past(cnt_wdata_i));

    // R10: escalation freezes the count
    a_r10_frozen_still: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FROZEN && !cnt_we_i) |=> $stable(count_q));

    // R4: sleep hold freezes the count
    a_r4_hold_still: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !cnt_we_i) |=> $stable(count_q));

    // R2: disabled counter does not move
    a_r2_idle_still: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !cnt_we_i) |=> $stable(count_q));

    // R10: escalation always reaches FROZEN on the next edge
    a_r10_esc_enters: assert property (@(posedge clk) disable iff (!rst_n)
        esc_i |=> state_q == ST_FROZEN);

endmodule

// File: rtl/wdg_cmp.sv
module wdg_cmp #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] thresh_i,
    input  logic             freeze_i,
    output logic             hit_o
);

    logic hit_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        hit_q <= 1'b0;
        else if (!freeze_i) hit_q <= (count_i >= thresh_i);
    end

    assign hit_o = hit_q;

    // R5 / R6: level rises after the count reaches the threshold
    a_r5_hit_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze_i && count_i >= thresh_i) |=> hit_q);

    // R5 / R6: level drops after the count is below the threshold
    a_r6_hit_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze_i && count_i < thresh_i) |=> !hit_q);

    // R10: level holds while frozen
    a_r10_hit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        freeze_i |=> $stable(hit_q));

endmodule

// File: rtl/barkbite_watchdog.sv
module barkbite_watchdog
    import wdg_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    input  logic             sleep_i,
    input  logic             esc_i,
    output logic             bark_irq,
    output logic             wake_req,
    output logic             bite_rst
);

    wdg_ctrl_t        ctrl;
    logic [CNT_W-1:0] bark_th, bite_th, count, cnt_wdata;
    logic             cnt_we;
    wdg_state_e       state;
    logic [CNT_W-1:0] thresh [NUM_CMP];
    logic [NUM_CMP-1:0] hits;

    wdg_regs #(.CNT_W(CNT_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .count_i     (count),
        .reg_rdata   (reg_rdata),
        .ctrl_o      (ctrl),
        .bark_th_o   (bark_th),
        .bite_th_o   (bite_th),
        .cnt_we_o    (cnt_we),
        .cnt_wdata_o (cnt_wdata)
    );

    wdg_core #(.CNT_W(CNT_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_i      (ctrl),
        .sleep_i     (sleep_i),
        .esc_i       (esc_i),
        .cnt_we_i    (cnt_we),
        .cnt_wdata_i (cnt_wdata),
        .count_o     (count),
        .state_o     (state)
    );

    assign thresh[0] = bark_th;
    assign thresh[1] = bite_th;

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        wdg_cmp #(.CNT_W(CNT_W)) u_cmp (
            .clk      (clk),
            .rst_n    (rst_n),
            .count_i  (count),
            .thresh_i (thresh[g]),
            .freeze_i (state == ST_FROZEN),
            .hit_o    (hits[g])
        );
    end

    assign bark_irq = hits[0];
    assign wake_req = hits[0];
    assign bite_rst = hits[1];

    // R5: wakeup request accompanies every bark
    a_r5_wake_with_bark: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bark_irq) |-> wake_req);

endmodule

// File: tb/tb_barkbite_watchdog.sv
`timescale 1ns/1ps
module tb_barkbite_watchdog;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_we = 1'b0;
    logic [2:0]   reg_addr = '0;
    logic [W-1:0] reg_wdata = '0;
    logic [W-1:0] reg_rdata;
    logic         sleep_i = 1'b0;
    logic         esc_i = 1'b0;
    logic         bark_irq, wake_req, bite_rst;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    barkbite_watchdog #(.CNT_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sleep_i(sleep_i),
        .esc_i(esc_i), .bark_irq(bark_irq), .wake_req(wake_req),
        .bite_rst(bite_rst)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            mismatched++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset values and map
        rd(3'd0, v); chk("R1 ctrl", v, 0);
        rd(3'd1, v); chk("R1 lock", v, 1);
        rd(3'd2, v); chk("R1 bark th", v, 8'hFF);
        rd(3'd3, v); chk("R1 bite th", v, 8'hFF);
        rd(3'd4, v); chk("R1 count", v, 0);
        rd(3'd6, v); chk("R1 unmapped", v, 0);
        chk("R1 outputs", {bark_irq, wake_req, bite_rst}, 0);

        // R2 disabled: no counting
        tick(5);
        rd(3'd4, v); chk("R2 idle count", v, 0);

        // R2 enable latency
        wr(3'd0, 8'h01);
        tick(10);
        rd(3'd4, v); chk("R2 count after enable", v, 9);

        // R5 bark sweep
        for (int th = 2; th < 256; th++) begin
            wr(3'd2, W'(th));
            wr(3'd4, W'(th - 2));
            tick(2);
            chk("R5 bark before", bark_irq, 0);
            rd(3'd4, v); chk("R5 count at th", v, th);
            tick(1);
            chk("R5 bark rise", bark_irq, 1);
            chk("R5 wake rise", wake_req, 1);
        end
        wr(3'd4, 8'h00);
        tick(1);
        chk("R5 bark clear", bark_irq, 0);
        wr(3'd2, 8'hFF);

        // R6 bite sweep
        for (int th = 2; th < 256; th++) begin
            wr(3'd3, W'(th));
            wr(3'd4, W'(th - 2));
            tick(2);
            chk("R6 bite before", bite_rst, 0);
            tick(1);
            chk("R6 bite rise", bite_rst, 1);
        end
        wr(3'd4, 8'h00);
        tick(1);
        chk("R6 bite clear", bite_rst, 0);

        // R3 saturation
        wr(3'd4, 8'd250);
        tick(20);
        rd(3'd4, v); chk("R3 saturate", v, 8'hFF);
        tick(3);
        rd(3'd4, v); chk("R3 no wrap", v, 8'hFF);

        // R4 sleep without pause option: counts
        sleep_i = 1'b1;
        wr(3'd4, 8'd10);
        tick(5);
        rd(3'd4, v); chk("R4 sleep ignored", v, 15);
        // R4 pause option
        wr(3'd0, 8'h03);
        tick(2);
        wr(3'd4, 8'd40);
        tick(10);
        rd(3'd4, v); chk("R4 held in sleep", v, 40);
        sleep_i = 1'b0;
        tick(5);
        rd(3'd4, v); chk("R4 resume", v, 44);

        // R10 escalation
        wr(3'd2, 8'd60);
        wr(3'd4, 8'd0);
        tick(1);
        esc_i = 1'b1;
        tick(2);
        wr(3'd4, 8'd100);
        tick(5);
        rd(3'd4, v); chk("R10 frozen count", v, 100);
        chk("R10 bark suppressed", bark_irq, 0);
        esc_i = 1'b0;
        tick(1);
        chk("R10 bark held one edge", bark_irq, 0);
        tick(1);
        chk("R10 bark after release", bark_irq, 1);
        rd(3'd4, v); chk("R10 count resumes", v, 101);

        // R7 lock
        wr(3'd1, 8'h01);
        rd(3'd1, v); chk("R7 write one ignored", v, 1);
        wr(3'd1, 8'h00);
        rd(3'd1, v); chk("R7 cleared", v, 0);
        wr(3'd1, 8'h01);
        rd(3'd1, v); chk("R7 sticky", v, 0);

        // R8 locked writes ignored
        wr(3'd0, 8'h00);
        rd(3'd0, v); chk("R8 ctrl kept", v, 3);
        wr(3'd2, 8'd7);
        rd(3'd2, v); chk("R8 bark kept", v, 60);
        wr(3'd3, 8'd9);
        rd(3'd3, v); chk("R8 bite kept", v, 8'hFF);

        // R9 pet while locked
        wr(3'd4, 8'd5);
        rd(3'd4, v); chk("R9 pet locked", v, 5);
        tick(3);
        rd(3'd4, v); chk("R9 still counting", v, 8);
        chk("R9 bark cleared by pet", bark_irq, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule